// File: doc/BRIEF.md
# Bandwidth Usage Monitor

This block keeps a table of event counters, one per monitoring ID, for a memory bandwidth controller. Software drives a 64-bit control register to either bind a counter to an event kind (reads, writes or both) and optionally to one access type, or to copy a counter into a read-only value register. Every command is checked in a fixed priority order, and the result is reported as a status code in the control register, which reads back the fields as they were written.

A traffic port reports each memory transaction with its monitoring ID, access type and a read/write flag. An armed counter whose binding matches the transaction increments by one. A freshly armed counter reads as zero with its invalid flag set until its first increment. A wrap of the count sets a sticky overflow flag.

A snapshot command takes one extra cycle: the busy flag is raised for exactly one cycle while the value register is loaded, and control writes seen while busy is high are dropped.

Top module: `bwmon_unit`

## Requirements
- R1: After reset the control register (offset select 0) and the value register (offset select 1) both read as zero.
- R2: A command whose monitoring ID (control bits 19:8) is at or above NUM_MON returns status 3 whatever its operation or event fields hold.
- R3: With a valid ID, an operation code (bits 4:0) other than 1 (bind) or 2 (snapshot) returns status 2.
- R4: A bind with an event code (bits 27:20) above 3 returns status 4; event 0 disarms, 1 counts reads and writes, 2 reads only, 3 writes only.
- R5: A bind with the access-type-valid bit (bit 28) set and an access type (bits 7:5) that is not supported returns status 5; type 0 is data, type 1 is code, types 2 to 7 are never supported.
- R6: A successful bind returns status 1 and clears the count to zero with the invalid flag (value bit 62) set and the overflow flag (bit 63) clear.
- R7: An armed counter increments once for each traffic event whose ID equals its own, whose read/write kind is selected by the bound event code, and whose access type equals the bound one when a type was bound; the first increment clears the invalid flag.
- R8: An increment from the all-ones count wraps to zero and sets the overflow flag, which stays set through later increments until the counter is bound again.
- R9: A successful snapshot returns status 1, sets the busy flag (bit 39) for exactly one cycle, and in the cycle that busy clears the value register holds the counter state with the count in its low bits.
- R10: A control write that arrives while busy is set is ignored and leaves every control field unchanged.
- R11: Writes to the value register have no effect on it.
- R12: A bind with event code 0 returns status 1 and stops counting while keeping the stored count.
- R13: The control register reads back the written operation, access type, ID, event and access-type-valid fields together with the new status; the status and busy bits of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 counter value |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for the selected register |
| ev_valid | input | 1 | Traffic event strobe |
| ev_mid | input | 12 | Monitoring ID of the traffic event |
| ev_at | input | 3 | Access type of the traffic event |
| ev_is_wr | input | 1 | 1 for a write transaction, 0 for a read |

## Verification
The bench builds the block with NUM_MON of 8, a 4-bit count and code access type disabled. The small ID range puts the out-of-range status within a few IDs, the narrow count lets sixteen events reach the wrap and the sticky overflow flag, and the missing code type exercises the access-type rejection for a value that a full build would accept. Validation order, counting rules by kind and type, disarm and the busy window are driven as directed sequences after a table of command vectors.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
   localparam int unsigned OP_W  = 5;
   localparam int unsigned AT_W  = 3;
   localparam int unsigned MID_W = 12;
   localparam int unsigned EVT_W = 8;
   localparam int unsigned ST_W  = 7;

   localparam logic [OP_W-1:0] OP_BIND = 5'd1;
   localparam logic [OP_W-1:0] OP_SNAP = 5'd2;

   typedef enum logic [ST_W-1:0] {
      ST_NONE    = 7'd0,
      ST_OK      = 7'd1,
      ST_BAD_OP  = 7'd2,
      ST_BAD_ID  = 7'd3,
      ST_BAD_EVT = 7'd4,
      ST_BAD_AT  = 7'd5
   } status_e;

   typedef enum logic [1:0] {
      KIND_OFF = 2'd0,
      KIND_ANY = 2'd1,
      KIND_RD  = 2'd2,
      KIND_WR  = 2'd3
   } kind_e;
endpackage

// File: rtl/bwmon_cmd_decode.sv
module bwmon_cmd_decode
   import bwmon_pkg::*;
#(
   parameter int unsigned NUM_MON    = 256,
   parameter bit          AT_DATA_EN = 1'b1,
   parameter bit          AT_CODE_EN = 1'b1
) (
   input  logic [OP_W-1:0]  op,
   input  logic [AT_W-1:0]  at_in,
   input  logic [MID_W-1:0] mid,
   input  logic [EVT_W-1:0] evt,
   input  logic             atv_in,
   output logic [AT_W-1:0]  at_eff,
   output logic             atv_eff,
   output status_e          status,
   output logic             do_arm,
   output logic             do_disarm,
   output logic             do_snap,
   output kind_e            kind
);
   localparam bit ANY_AT = AT_DATA_EN || AT_CODE_EN;

   generate
      if (ANY_AT) begin : g_at_pass
         assign at_eff  = at_in;
         assign atv_eff = atv_in;
      end else begin : g_at_tie
         assign at_eff  = '0;
         assign atv_eff = 1'b0;
      end
   endgenerate

   logic at_ok;
   logic id_ok;
   assign at_ok = (at_eff == 3'd0 && AT_DATA_EN) || (at_eff == 3'd1 && AT_CODE_EN);
   assign id_ok = 32'(mid) < NUM_MON;
   assign kind  = kind_e'(evt[1:0]);

   always_comb begin
      status    = ST_BAD_OP;
      do_arm    = 1'b0;
      do_disarm = 1'b0;
      do_snap   = 1'b0;
      if (!id_ok) begin
         status = ST_BAD_ID;
      end else if (op == OP_BIND) begin
         if (evt == 8'd0) begin
            status    = ST_OK;
            do_disarm = 1'b1;
         end else if (evt <= 8'd3) begin
            if (atv_eff && !at_ok) begin
               status = ST_BAD_AT;
            end else begin
               status = ST_OK;
               do_arm = 1'b1;
            end
         end else begin
            status = ST_BAD_EVT;
         end
      end else if (op == OP_SNAP) begin
         status  = ST_OK;
         do_snap = 1'b1;
      end
   end
endmodule

// File: rtl/bwmon_ctr_table.sv
module bwmon_ctr_table
   import bwmon_pkg::*;
#(
   parameter int unsigned NUM_MON = 256,
   parameter int unsigned CNT_W   = 62,
   parameter int unsigned IDX_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              disarm,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  kind_e             cfg_kind,
   input  logic              cfg_atb,
   input  logic [AT_W-1:0]   cfg_at,
   input  logic              ev_valid,
   input  logic              ev_in_range,
   input  logic [IDX_W-1:0]  ev_idx,
   input  logic [AT_W-1:0]   ev_at,
   input  logic              ev_is_wr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic              rd_inv,
   output logic              rd_ovf
);
   logic             armed_q [NUM_MON];
   kind_e            kind_q  [NUM_MON];
   logic             atb_q   [NUM_MON];
   logic [AT_W-1:0]  at_q    [NUM_MON];
   logic [CNT_W-1:0] cnt_q   [NUM_MON];
   logic             inv_q   [NUM_MON];
   logic             ovf_q   [NUM_MON];

   logic kind_hit;
   logic at_hit;
   logic hit;

   always_comb begin
      kind_hit = 1'b0;
      at_hit   = 1'b0;
      hit      = 1'b0;
      if (ev_valid && ev_in_range) begin
         unique case (kind_q[ev_idx])
            KIND_ANY: kind_hit = 1'b1;
            KIND_RD:  kind_hit = !ev_is_wr;
            KIND_WR:  kind_hit = ev_is_wr;
            default:  kind_hit = 1'b0;
         endcase
         at_hit = !atb_q[ev_idx] || (at_q[ev_idx] == ev_at);
         hit    = armed_q[ev_idx] && kind_hit && at_hit &&
                  !((arm || disarm) && (cfg_idx == ev_idx));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_MON); i++) begin
            armed_q[i] <= 1'b0;
            kind_q[i]  <= KIND_OFF;
            atb_q[i]   <= 1'b0;
            at_q[i]    <= '0;
            cnt_q[i]   <= '0;
            inv_q[i]   <= 1'b0;
            ovf_q[i]   <= 1'b0;
         end
      end else begin
         if (hit) begin
            cnt_q[ev_idx] <= cnt_q[ev_idx] + 1'b1;
            inv_q[ev_idx] <= 1'b0;
            if (&cnt_q[ev_idx]) ovf_q[ev_idx] <= 1'b1;
         end
         if (arm) begin
            armed_q[cfg_idx] <= 1'b1;
            kind_q[cfg_idx]  <= cfg_kind;
            atb_q[cfg_idx]   <= cfg_atb;
            at_q[cfg_idx]    <= cfg_at;
            cnt_q[cfg_idx]   <= '0;
            inv_q[cfg_idx]   <= 1'b1;
            ovf_q[cfg_idx]   <= 1'b0;
         end else if (disarm) begin
            armed_q[cfg_idx] <= 1'b0;
         end
      end
   end

   assign rd_cnt = cnt_q[rd_idx];
   assign rd_inv = inv_q[rd_idx];
   assign rd_ovf = ovf_q[rd_idx];
endmodule

// File: rtl/bwmon_unit.sv
module bwmon_unit
   import bwmon_pkg::*;
#(
   parameter int unsigned NUM_MON    = 256,
   parameter int unsigned CNT_W      = 62,
   parameter bit          AT_DATA_EN = 1'b1,
   parameter bit          AT_CODE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_addr,
   input  logic [63:0] reg_wdata,
   output logic [63:0] reg_rdata,
   input  logic        ev_valid,
   input  logic [11:0] ev_mid,
   input  logic [2:0]  ev_at,
   input  logic        ev_is_wr
);
   localparam int unsigned IDX_W = (NUM_MON > 1) ? $clog2(NUM_MON) : 1;

   generate
      if (NUM_MON < 1 || NUM_MON > 4096) begin : g_bad_num
         $error("bwmon_unit: NUM_MON must lie in 1..4096");
      end
      if (CNT_W < 1 || CNT_W > 62) begin : g_bad_cnt
         $error("bwmon_unit: CNT_W must lie in 1..62");
      end
   endgenerate

   logic [OP_W-1:0]  op_q;
   logic [AT_W-1:0]  at_q;
   logic [MID_W-1:0] mid_q;
   logic [EVT_W-1:0] evt_q;
   logic             atv_q;
   status_e          st_q;
   logic             busy_q;
   logic [63:0]      val_word;
   logic [63:0]      ctl_word;

   logic [AT_W-1:0] dec_at;
   logic            dec_atv;
   status_e         dec_st;
   logic            dec_arm;
   logic            dec_disarm;
   logic            dec_snap;
   kind_e           dec_kind;
   logic            accept;

   assign accept = reg_wr && !reg_addr && !busy_q;

   bwmon_cmd_decode #(
      .NUM_MON   (NUM_MON),
      .AT_DATA_EN(AT_DATA_EN),
      .AT_CODE_EN(AT_CODE_EN)
   ) u_dec (
      .op       (reg_wdata[4:0]),
      .at_in    (reg_wdata[7:5]),
      .mid      (reg_wdata[19:8]),
      .evt      (reg_wdata[27:20]),
      .atv_in   (reg_wdata[28]),
      .at_eff   (dec_at),
      .atv_eff  (dec_atv),
      .status   (dec_st),
      .do_arm   (dec_arm),
      .do_disarm(dec_disarm),
      .do_snap  (dec_snap),
      .kind     (dec_kind)
   );

   logic [CNT_W-1:0] rd_cnt;
   logic             rd_inv;
   logic             rd_ovf;

   bwmon_ctr_table #(
      .NUM_MON(NUM_MON),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (accept && dec_arm),
      .disarm     (accept && dec_disarm),
      .cfg_idx    (reg_wdata[8 +: IDX_W]),
      .cfg_kind   (dec_kind),
      .cfg_atb    (dec_atv),
      .cfg_at     (dec_at),
      .ev_valid   (ev_valid),
      .ev_in_range(32'(ev_mid) < NUM_MON),
      .ev_idx     (ev_mid[IDX_W-1:0]),
      .ev_at      (ev_at),
      .ev_is_wr   (ev_is_wr),
      .rd_idx     (mid_q[IDX_W-1:0]),
      .rd_cnt     (rd_cnt),
      .rd_inv     (rd_inv),
      .rd_ovf     (rd_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= '0;
         at_q     <= '0;
         mid_q    <= '0;
         evt_q    <= '0;
         atv_q    <= 1'b0;
         st_q     <= ST_NONE;
         busy_q   <= 1'b0;
         val_word <= '0;
      end else if (busy_q) begin
         val_word <= {rd_ovf, rd_inv, 62'(rd_cnt)};
         busy_q   <= 1'b0;
      end else if (accept) begin
         op_q   <= reg_wdata[4:0];
         at_q   <= dec_at;
         mid_q  <= reg_wdata[19:8];
         evt_q  <= reg_wdata[27:20];
         atv_q  <= dec_atv;
         st_q   <= dec_st;
         busy_q <= dec_snap;
      end
   end

   assign ctl_word  = {24'd0, busy_q, st_q, 3'd0, atv_q, evt_q, mid_q, at_q, op_q};
   assign reg_rdata = reg_addr ? val_word : ctl_word;
endmodule

// File: rtl/bwmon_checker.sv
module bwmon_checker #(
   parameter int unsigned NUM_MON = 256
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_addr,
   input logic [63:0] reg_wdata,
   input logic [63:0] ctl_word,
   input logic [63:0] val_word
);
   logic wr_ctl;
   assign wr_ctl = reg_wr && !reg_addr;

   AST_BAD_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !ctl_word[39] && (32'(reg_wdata[19:8]) >= NUM_MON))
      |=> (ctl_word[38:32] == 7'd3)); // R2

   AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !ctl_word[39] && (32'(reg_wdata[19:8]) < NUM_MON) &&
       (reg_wdata[4:0] != 5'd1) && (reg_wdata[4:0] != 5'd2))
      |=> (ctl_word[38:32] == 7'd2)); // R3

   AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_word[39] |=> !ctl_word[39]); // R9

   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && ctl_word[39]) |=> (ctl_word[38:0] == $past(ctl_word[38:0]))); // R10

   AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_word[39] |=> $stable(val_word)); // R11
endmodule

bind bwmon_unit bwmon_checker #(.NUM_MON(NUM_MON)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .ctl_word (ctl_word),
   .val_word (val_word)
);

// File: tb/bwmon_unit_tb.sv
module bwmon_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        ev_valid = 1'b0;
   logic [11:0] ev_mid = '0;
   logic [2:0]  ev_at = '0;
   logic        ev_is_wr = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bwmon_unit #(.NUM_MON(8), .CNT_W(4), .AT_DATA_EN(1'b1), .AT_CODE_EN(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
      .ev_mid(ev_mid), .ev_at(ev_at), .ev_is_wr(ev_is_wr));

   // {op[5], at[3], mid[12], evt[8], atv[1], expected status[3]}
   localparam logic [31:0] VEC [9] = '{
      {5'd1, 3'd0, 12'd9, 8'd1, 1'b0, 3'd3},  // R2 id out of range
      {5'd7, 3'd0, 12'd9, 8'd9, 1'b0, 3'd3},  // R2 id before op
      {5'd0, 3'd0, 12'd2, 8'd1, 1'b0, 3'd2},  // R3
      {5'd3, 3'd0, 12'd2, 8'd1, 1'b0, 3'd2},  // R3
      {5'd1, 3'd0, 12'd2, 8'd4, 1'b0, 3'd4},  // R4
      {5'd1, 3'd1, 12'd2, 8'd1, 1'b1, 3'd5},  // R5 code type disabled
      {5'd1, 3'd3, 12'd2, 8'd2, 1'b1, 3'd5},  // R5 reserved type
      {5'd1, 3'd1, 12'd2, 8'd1, 1'b0, 3'd1},  // R6 type ignored without valid bit
      {5'd1, 3'd0, 12'd7, 8'd3, 1'b1, 3'd1}   // R6 writes, data type bound
   };

   function automatic logic [63:0] mk(input logic [4:0] op, input logic [2:0] at,
                                      input logic [11:0] mid, input logic [7:0] evt,
                                      input logic atv);
      return {35'd0, atv, evt, mid, at, op};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic ev(input logic [11:0] id, input logic [2:0] at, input logic w);
      @(negedge clk);
      ev_valid = 1'b1; ev_mid = id; ev_at = at; ev_is_wr = w;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic snap(input logic [11:0] id, output logic [63:0] v);
      logic [63:0] c;
      wr(1'b0, mk(5'd2, 3'd0, id, 8'd0, 1'b0));
      rd(1'b0, c);
      chk("R9 busy raised", {62'd0, c[39], c[38:32] == 7'd1}, 64'd3);
      @(negedge clk);
      rd(1'b0, c);
      chk("R9 busy cleared", {63'd0, c[39]}, 64'd0);
      rd(1'b1, v);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [63:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(1'b0, d); chk("R1 control after reset", d, 64'd0);
      rd(1'b1, d); chk("R1 value after reset", d, 64'd0);

      // R13: status/busy bits and upper bits of the write data are junk
      for (int i = 0; i < 9; i++) begin
         logic [31:0] v;
         logic [63:0] w;
         v = VEC[i];
         w = mk(v[31:27], v[26:24], v[23:12], v[11:4], v[3]) | 64'hFFFF_FFFF_0000_0000;
         wr(1'b0, w);
         rd(1'b0, c);
         chk("R2-R6 status", {57'd0, c[38:32]}, {61'd0, v[2:0]});
         chk("R13 readback", {35'd0, c[28:0]}, {35'd0, w[28:0]});
      end

      snap(12'd2, d); chk("R6 armed counter", d, 64'h4000_0000_0000_0000);

      // R10: second write lands while busy
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = mk(5'd2, 3'd0, 12'd2, 8'd0, 1'b0);
      @(negedge clk);
      reg_wdata = mk(5'd7, 3'd0, 12'd1, 8'd0, 1'b0);
      @(negedge clk);
      reg_wr = 1'b0;
      rd(1'b0, c);
      chk("R10 write ignored while busy", c, {25'd0, 7'd1, 3'd0, 1'b0, 8'd0, 12'd2, 3'd0, 5'd2});

      // R7: counter 2 counts all kinds, any type
      ev(12'd2, 3'd0, 1'b0);
      ev(12'd2, 3'd1, 1'b1);
      ev(12'd3, 3'd0, 1'b0);
      snap(12'd2, d); chk("R7 any kind", d, 64'd2);
      // R7: counter 7 counts data writes only
      ev(12'd7, 3'd0, 1'b1);
      ev(12'd7, 3'd0, 1'b0);
      ev(12'd7, 3'd1, 1'b1);
      ev(12'd7, 3'd0, 1'b1);
      snap(12'd7, d); chk("R7 kind and type filter", d, 64'd2);

      // R8: wrap of 4-bit count
      for (int k = 0; k < 13; k++) ev(12'd2, 3'd0, 1'b0);
      snap(12'd2, d); chk("R8 at all ones", d, 64'd15);
      ev(12'd2, 3'd0, 1'b0);
      snap(12'd2, d); chk("R8 wrap sets overflow", d, 64'h8000_0000_0000_0000);
      ev(12'd2, 3'd0, 1'b1);
      snap(12'd2, d); chk("R8 overflow sticky", d, 64'h8000_0000_0000_0001);
      wr(1'b0, mk(5'd1, 3'd0, 12'd2, 8'd1, 1'b0));
      snap(12'd2, d); chk("R8 rebind clears overflow", d, 64'h4000_0000_0000_0000);

      // R12: disarm keeps the count
      wr(1'b0, mk(5'd1, 3'd0, 12'd7, 8'd0, 1'b0));
      rd(1'b0, c); chk("R12 disarm status", {57'd0, c[38:32]}, 64'd1);
      ev(12'd7, 3'd0, 1'b1);
      snap(12'd7, d); chk("R12 count retained", d, 64'd2);

      // R11: value register is read-only
      wr(1'b1, 64'h1234_5678_9ABC_DEF0);
      rd(1'b1, d); chk("R11 value read-only", d, 64'd2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule